// File: doc/BRIEF.md
# Latency-Tagged Scoreboard Issue Unit

The block is an in-order, single-issue execution core for 128-bit SIMD registers. Each register holds four 32-bit lanes. Software loads a short program into a small instruction store, preloads the register file, sets the program length and pulses `start`. The core then steps through the program one instruction at a time. A register is either settled or waiting on a result that has not landed yet. A waiting register carries the cycle number on which its new value becomes readable. An instruction whose sources are still waiting holds in place until they settle.

When an instruction issues, its lane-wise result is computed at once. That result is parked beside the destination with a tag equal to the current cycle plus the opcode's fixed latency. A later instruction aimed at a destination that is still waiting replaces both the parked value and its tag. When the program is exhausted and nothing is waiting any more, the core raises `done` and reports how many cycles the run took. The typical use is to compare the cycle cost of instruction orderings, for example a dependent pair against an independent pair.

Top module: `simd_scoreboard_core`

## Requirements
- R1: While reset is held, and after it is released and before any start, `running` and `done` are 0 and `cycle_count` is 0.
- R2: An instruction word is 11 bits: bits [10:9] opcode, [8:6] destination, [5:3] source A, [2:0] source B, with each index selecting one of 8 registers.
- R3: Opcodes act on each 32-bit lane separately, with no carry between lanes: 0 = A+B modulo 2^32, 1 = A-B modulo 2^32, 2 = copy of A, 3 = A XOR B.
- R4: Fixed latencies are 2 for opcode 0, 4 for opcode 1, 1 for opcode 2 and 3 for opcode 3. A result issued on run cycle t is readable by a later instruction on cycle t+latency, and not before.
- R5: An instruction does not issue while either of its two source fields names a register with a result still in progress, whatever the opcode. Issue happens on the first cycle on which both sources are settled.
- R6: At most one instruction issues per cycle, strictly in program order, starting from entry 0 on the first run cycle.
- R7: An instruction whose destination still has a pending result replaces that pending value and ready cycle. The register ends with the later instruction's value, and readers wait only for the later ready cycle.
- R8: Run cycles are numbered from 0. `done` rises once every instruction has issued and no register is pending, and `cycle_count` is then the largest ready cycle of any issued result. This is 0 for an empty program.
- R9: Once set, `done` and `cycle_count` hold until the next `start`. A `start` while done begins a new run, dropping `done` and raising `running` one cycle later.
- R10: Register preload writes and instruction-store writes arriving while `running` is 1 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_we | input | 1 | Instruction store write enable |
| imem_addr | input | 4 | Instruction store write address |
| imem_wdata | input | 11 | Instruction word to store |
| prog_len | input | 5 | Number of instructions in the program (0 to 16) |
| reg_we | input | 1 | Register preload write enable |
| reg_widx | input | 3 | Register preload index |
| reg_wdata | input | 128 | Register preload value |
| reg_ridx | input | 3 | Register readback index |
| reg_rdata | output | 128 | Settled value of the register selected by reg_ridx |
| start | input | 1 | Begin a run from instruction 0 |
| running | output | 1 | A run is in progress |
| done | output | 1 | The last run has completed |
| cycle_count | output | 16 | Length of the last run in cycles |

## Verification
Two kinds of fault are visible at the ports. A stuck or wrong pending flag either holds the program back for good or lets a reader take a stale value. A hang is caught by a bounded wait. A stale read shows as a wrong lane in the final register readback, since that value then feeds the later results. A wrong tag, or a pending entry that is not replaced, moves `cycle_count` away from the largest ready cycle of the program, and this shows as soon as `done` rises. Dependent against independent pairs, overwrites that shorten a wait, and randomized programs each expose these faults within one run.

// File: rtl/scb_pkg.sv
package scb_pkg;

  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_MOV = 2'd2,
    OP_XOR = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } st_e;

endpackage

// File: rtl/scb_lane_alu.sv
module scb_lane_alu
  import scb_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int LANE_W = 32,
  localparam int DW    = LANES * LANE_W
) (
  input  op_e           op,
  input  logic [DW-1:0] src_a,
  input  logic [DW-1:0] src_b,
  output logic [DW-1:0] result
);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] la, lb, ly;
    assign la = src_a[l*LANE_W +: LANE_W];
    assign lb = src_b[l*LANE_W +: LANE_W];
    always_comb begin
      case (op)
        OP_ADD:  ly = la + lb;
        OP_SUB:  ly = la - lb;
        OP_MOV:  ly = la;
        default: ly = la ^ lb;
      endcase
    end
    assign result[l*LANE_W +: LANE_W] = ly;
  end

endmodule

// File: rtl/scb_regfile_sb.sv
module scb_regfile_sb #(
  parameter int NREG  = 8,
  parameter int DW    = 128,
  parameter int CYC_W = 16,
  localparam int RIW  = $clog2(NREG)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  run,
  input  logic [CYC_W-1:0]      cyc,
  input  logic                  iss_en,
  input  logic [RIW-1:0]        iss_dst,
  input  logic [CYC_W-1:0]      iss_tag,
  input  logic [DW-1:0]         iss_val,
  input  logic                  ext_we,
  input  logic [RIW-1:0]        ext_idx,
  input  logic [DW-1:0]         ext_val,
  input  logic [RIW-1:0]        ra_idx,
  input  logic [RIW-1:0]        rb_idx,
  input  logic [RIW-1:0]        rx_idx,
  output logic [DW-1:0]         ra_val,
  output logic [DW-1:0]         rb_val,
  output logic [DW-1:0]         rx_val,
  output logic [NREG-1:0]       busy,
  output logic [NREG*CYC_W-1:0] tags
);

  logic [DW-1:0]    arch_w [NREG];
  logic [CYC_W-1:0] cyc_nx;

  assign cyc_nx = cyc + 1'b1;

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic             hit, direct, due;
    logic             arch_en, pend_en, busy_d;
    logic [DW-1:0]    arch_d;
    logic [DW-1:0]    arch_r, pend_r;
    logic [CYC_W-1:0] tag_r;
    logic             busy_r;

    // Next-state: a latency-1 issue lands straight in the settled copy,
    // anything longer is parked with its tag; a due entry drains on the
    // cycle before its tag so it is readable on the tag cycle.
    always_comb begin
      hit     = iss_en && (iss_dst == RIW'(r));
      direct  = (iss_tag == cyc_nx);
      due     = run && busy_r && (tag_r == cyc_nx);
      arch_en = 1'b0;
      arch_d  = ext_val;
      pend_en = 1'b0;
      busy_d  = busy_r;
      if (hit && direct) begin
        arch_en = 1'b1;
        arch_d  = iss_val;
        busy_d  = 1'b0;
      end else begin
        if (due) begin
          arch_en = 1'b1;
          arch_d  = pend_r;
          busy_d  = 1'b0;
        end else if (ext_we && (ext_idx == RIW'(r))) begin
          arch_en = 1'b1;
          arch_d  = ext_val;
        end
        if (hit) begin
          pend_en = 1'b1;
          busy_d  = 1'b1;
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) busy_r <= 1'b0;
      else        busy_r <= busy_d;
    end

    always_ff @(posedge clk) begin
      if (arch_en) arch_r <= arch_d;
    end

    always_ff @(posedge clk) begin
      if (pend_en) begin
        pend_r <= iss_val;
        tag_r  <= iss_tag;
      end
    end

    assign arch_w[r]                  = arch_r;
    assign busy[r]                    = busy_r;
    assign tags[r*CYC_W +: CYC_W]     = tag_r;
  end

  assign ra_val = arch_w[ra_idx];
  assign rb_val = arch_w[rb_idx];
  assign rx_val = arch_w[rx_idx];

endmodule

// File: rtl/scb_issue_ctrl.sv
module scb_issue_ctrl
  import scb_pkg::*;
#(
  parameter int AW    = 4,
  parameter int CYC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [AW:0]      prog_len,
  input  logic             src_hold,
  input  logic             any_busy,
  output logic             run,
  output logic             done,
  output logic             issue,
  output logic [AW:0]      pc,
  output logic [CYC_W-1:0] cyc,
  output logic [CYC_W-1:0] cycle_count
);

  st_e              st_q, st_d;
  logic [AW:0]      pc_q, pc_d;
  logic [CYC_W-1:0] cyc_q, cyc_d;
  logic [CYC_W-1:0] cnt_q, cnt_d;
  logic             have, finish;

  always_comb begin
    have   = (pc_q < prog_len);
    issue  = (st_q == ST_RUN) && have && !src_hold;
    finish = (st_q == ST_RUN) && !have && !any_busy;
    st_d   = st_q;
    pc_d   = pc_q;
    cyc_d  = cyc_q;
    cnt_d  = cnt_q;
    case (st_q)
      ST_RUN: begin
        cyc_d = cyc_q + 1'b1;
        if (issue) pc_d = pc_q + 1'b1;
        if (finish) begin
          st_d  = ST_DONE;
          cnt_d = cyc_q;
        end
      end
      default: begin
        if (start) begin
          st_d  = ST_RUN;
          pc_d  = '0;
          cyc_d = '0;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      pc_q  <= '0;
      cyc_q <= '0;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      pc_q  <= pc_d;
      cyc_q <= cyc_d;
      cnt_q <= cnt_d;
    end
  end

  assign run         = (st_q == ST_RUN);
  assign done        = (st_q == ST_DONE);
  assign pc          = pc_q;
  assign cyc         = cyc_q;
  assign cycle_count = cnt_q;

endmodule

// File: rtl/simd_scoreboard_core.sv
module simd_scoreboard_core
  import scb_pkg::*;
#(
  parameter int NREG       = 8,
  parameter int LANES      = 4,
  parameter int LANE_W     = 32,
  parameter int IMEM_DEPTH = 16,
  parameter int CYC_W      = 16,
  parameter int LAT_ADD    = 2,
  parameter int LAT_SUB    = 4,
  parameter int LAT_MOV    = 1,
  parameter int LAT_XOR    = 3,
  localparam int RIW       = $clog2(NREG),
  localparam int AW        = $clog2(IMEM_DEPTH),
  localparam int DW        = LANES * LANE_W,
  localparam int IW        = 2 + 3 * RIW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             imem_we,
  input  logic [AW-1:0]    imem_addr,
  input  logic [IW-1:0]    imem_wdata,
  input  logic [AW:0]      prog_len,
  input  logic             reg_we,
  input  logic [RIW-1:0]   reg_widx,
  input  logic [DW-1:0]    reg_wdata,
  input  logic [RIW-1:0]   reg_ridx,
  output logic [DW-1:0]    reg_rdata,
  input  logic             start,
  output logic             running,
  output logic             done,
  output logic [CYC_W-1:0] cycle_count
);

  // Reset: asserted asynchronously, released through two flops.
  logic [1:0] rs_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  logic                  run_w, issue_w, src_hold_w, any_busy_w;
  logic [AW:0]           pc_w;
  logic [CYC_W-1:0]      cyc_w, lat_w, iss_tag_w;
  logic [IW-1:0]         instr_w;
  op_e                   op_w;
  logic [RIW-1:0]        dst_w, sa_w, sb_w;
  logic [DW-1:0]         va_w, vb_w, res_w;
  logic [NREG-1:0]       busy_w;
  logic [NREG*CYC_W-1:0] tags_w;

  // Instruction store: writable only outside a run.
  logic [IW-1:0] imem_q [IMEM_DEPTH];

  always_ff @(posedge clk) begin
    if (imem_we && !run_w) imem_q[imem_addr] <= imem_wdata;
  end

  assign instr_w = imem_q[pc_w[AW-1:0]];
  assign op_w    = op_e'(instr_w[IW-1 -: 2]);
  assign dst_w   = instr_w[3*RIW-1 -: RIW];
  assign sa_w    = instr_w[2*RIW-1 -: RIW];
  assign sb_w    = instr_w[RIW-1:0];

  assign src_hold_w = busy_w[sa_w] | busy_w[sb_w];
  assign any_busy_w = |busy_w;

  always_comb begin
    case (op_w)
      OP_ADD:  lat_w = CYC_W'(LAT_ADD);
      OP_SUB:  lat_w = CYC_W'(LAT_SUB);
      OP_MOV:  lat_w = CYC_W'(LAT_MOV);
      default: lat_w = CYC_W'(LAT_XOR);
    endcase
  end
  assign iss_tag_w = cyc_w + lat_w;

  scb_issue_ctrl #(.AW(AW), .CYC_W(CYC_W)) ctrl_i (
    .clk(clk), .rst_n(rst_int_n), .start(start), .prog_len(prog_len),
    .src_hold(src_hold_w), .any_busy(any_busy_w), .run(run_w), .done(done),
    .issue(issue_w), .pc(pc_w), .cyc(cyc_w), .cycle_count(cycle_count)
  );

  scb_lane_alu #(.LANES(LANES), .LANE_W(LANE_W)) alu_i (
    .op(op_w), .src_a(va_w), .src_b(vb_w), .result(res_w)
  );

  scb_regfile_sb #(.NREG(NREG), .DW(DW), .CYC_W(CYC_W)) sb_i (
    .clk(clk), .rst_n(rst_int_n), .run(run_w), .cyc(cyc_w),
    .iss_en(issue_w), .iss_dst(dst_w), .iss_tag(iss_tag_w), .iss_val(res_w),
    .ext_we(reg_we && !run_w), .ext_idx(reg_widx), .ext_val(reg_wdata),
    .ra_idx(sa_w), .rb_idx(sb_w), .rx_idx(reg_ridx),
    .ra_val(va_w), .rb_val(vb_w), .rx_val(reg_rdata),
    .busy(busy_w), .tags(tags_w)
  );

  assign running = run_w;

endmodule

// File: rtl/scb_core_checker.sv
module scb_core_checker #(
  parameter int NREG  = 8,
  parameter int CYC_W = 16,
  parameter int AW    = 4,
  parameter int RIW   = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  run,
  input logic                  done,
  input logic                  start,
  input logic [CYC_W-1:0]      cycle_count,
  input logic [AW:0]           pc,
  input logic [CYC_W-1:0]      cyc,
  input logic                  issue,
  input logic [RIW-1:0]        iss_dst,
  input logic [CYC_W-1:0]      iss_tag,
  input logic [NREG-1:0]       busy,
  input logic [NREG*CYC_W-1:0] tags
);

  // R8: completion leaves nothing pending
  a_r8_done_no_pending: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (busy == '0));

  // R9: done and the count hold until a new start
  a_r9_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(cycle_count)));

  // R6: program counter advances by at most one per cycle
  a_r6_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run)) |-> (pc == $past(pc) || pc == $past(pc) + 1'b1));

  // R8: run cycle numbering advances by one each cycle
  a_r8_cyc_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run)) |-> (cyc == $past(cyc) + 1'b1));

  for (genvar r = 0; r < NREG; r++) begin : g_chk
    logic [CYC_W-1:0] tag_r;
    assign tag_r = tags[r*CYC_W +: CYC_W];

    // R4: a pending entry is always tagged for a future cycle
    a_r4_tag_ahead: assert property (@(posedge clk) disable iff (!rst_n)
      (run && busy[r]) |-> (tag_r > cyc));

    // R4: an entry due next cycle drains unless replaced
    a_r4_drain: assert property (@(posedge clk) disable iff (!rst_n)
      (run && busy[r] && tag_r == cyc + 1'b1 && !(issue && iss_dst == RIW'(r)))
      |=> !busy[r]);

    // R7: a parked issue replaces the pending value's tag
    a_r7_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && iss_dst == RIW'(r) && iss_tag != cyc + 1'b1)
      |=> (busy[r] && tag_r == $past(iss_tag)));
  end

endmodule

bind simd_scoreboard_core scb_core_checker #(
  .NREG(NREG), .CYC_W(CYC_W), .AW(AW), .RIW(RIW)
) chk_i (
  .clk(clk), .rst_n(rst_n), .run(run_w), .done(done), .start(start),
  .cycle_count(cycle_count), .pc(pc_w), .cyc(cyc_w), .issue(issue_w),
  .iss_dst(dst_w), .iss_tag(iss_tag_w), .busy(busy_w), .tags(tags_w)
);

// File: tb/simd_scoreboard_core_tb_top.sv
`timescale 1ns/1ps
module simd_scoreboard_core_tb_top;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         imem_we;
  logic [3:0]   imem_addr;
  logic [10:0]  imem_wdata;
  logic [4:0]   prog_len;
  logic         reg_we;
  logic [2:0]   reg_widx;
  logic [127:0] reg_wdata;
  logic [2:0]   reg_ridx;
  logic [127:0] reg_rdata;
  logic         start;
  logic         running;
  logic         done;
  logic [15:0]  cycle_count;

  always #2.5 clk = ~clk;

  simd_scoreboard_core dut_i (
    .clk(clk), .rst_n(rst_n), .imem_we(imem_we), .imem_addr(imem_addr),
    .imem_wdata(imem_wdata), .prog_len(prog_len), .reg_we(reg_we),
    .reg_widx(reg_widx), .reg_wdata(reg_wdata), .reg_ridx(reg_ridx),
    .reg_rdata(reg_rdata), .start(start), .running(running), .done(done),
    .cycle_count(cycle_count)
  );

  int n_chk = 0;
  int n_err = 0;

  logic [10:0]  prog [16];
  int           plen;
  logic [127:0] init_regs [8];
  logic [127:0] exp_regs [8];
  int           exp_cyc;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // R2 word layout: op[10:9] dst[8:6] a[5:3] b[2:0]
  function automatic logic [10:0] enc(int op, int d, int a, int b);
    return {2'(op), 3'(d), 3'(a), 3'(b)};
  endfunction

  function automatic int lat_of(logic [1:0] op);
    case (op)
      2'd0: return 2;
      2'd1: return 4;
      2'd2: return 1;
      default: return 3;
    endcase
  endfunction

  function automatic logic [127:0] lane_op(logic [1:0] op, logic [127:0] a, logic [127:0] b);
    logic [127:0] y;
    for (int l = 0; l < 4; l++) begin
      logic [31:0] la, lb;
      la = a[l*32 +: 32];
      lb = b[l*32 +: 32];
      case (op)
        2'd0: y[l*32 +: 32] = la + lb;
        2'd1: y[l*32 +: 32] = la - lb;
        2'd2: y[l*32 +: 32] = la;
        default: y[l*32 +: 32] = la ^ lb;
      endcase
    end
    return y;
  endfunction

  // Reference: values follow program order (sources are always settled),
  // timing follows the stall and overwrite rules.
  task automatic model();
    int rdy [8];
    int t;
    for (int r = 0; r < 8; r++) begin
      exp_regs[r] = init_regs[r];
      rdy[r] = 0;
    end
    t = 0;
    for (int i = 0; i < plen; i++) begin
      logic [1:0] op;
      int d, a, b, ti;
      op = prog[i][10:9];
      d  = int'(prog[i][8:6]);
      a  = int'(prog[i][5:3]);
      b  = int'(prog[i][2:0]);
      ti = t;
      if (rdy[a] > ti) ti = rdy[a];
      if (rdy[b] > ti) ti = rdy[b];
      exp_regs[d] = lane_op(op, exp_regs[a], exp_regs[b]);
      rdy[d] = ti + lat_of(op);
      t = ti + 1;
    end
    exp_cyc = 0;
    for (int r = 0; r < 8; r++) if (rdy[r] > exp_cyc) exp_cyc = rdy[r];
  endtask

  task automatic do_run(input string nm, input bit poke);
    int n;
    for (int i = 0; i < plen; i++) begin
      @(negedge clk);
      imem_we = 1'b1; imem_addr = 4'(i); imem_wdata = prog[i];
    end
    @(negedge clk);
    imem_we = 1'b0;
    for (int r = 0; r < 8; r++) begin
      @(negedge clk);
      reg_we = 1'b1; reg_widx = 3'(r); reg_wdata = init_regs[r];
    end
    @(negedge clk);
    reg_we = 1'b0; prog_len = 5'(plen); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R9: a fresh start clears done and raises running
    chk(!done && running, "R9", {nm, " restart flags"}, {done, running}, 2'b01);
    if (poke) begin
      // R10: writes during a run must be dropped
      reg_we = 1'b1; reg_widx = 3'd7; reg_wdata = {4{32'hDEAD_BEEF}};
      imem_we = 1'b1; imem_addr = 4'd0; imem_wdata = enc(3, 7, 7, 7);
      @(negedge clk);
      reg_we = 1'b0; imem_we = 1'b0;
    end
    n = 0;
    while (!done && n < 3000) begin
      @(negedge clk);
      n++;
    end
    model();
    chk(done == 1'b1, "R8", {nm, " done within bound"}, done, 1'b1);
    chk(cycle_count == 16'(exp_cyc), "R8", {nm, " cycle count"}, cycle_count, exp_cyc);
    for (int r = 0; r < 8; r++) begin
      reg_ridx = 3'(r);
      #1;
      chk(reg_rdata == exp_regs[r], "R3", $sformatf("%s reg %0d", nm, r), reg_rdata, exp_regs[r]);
    end
  endtask

  task automatic rand_regs();
    for (int r = 0; r < 8; r++)
      init_regs[r] = {$urandom, $urandom, $urandom, $urandom};
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_err++;
    $display("FAIL R8 watchdog expired: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int c_ind, c_dep;
    logic [15:0] held;
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0; imem_we = 1'b0; imem_addr = '0; imem_wdata = '0;
    prog_len = '0; reg_we = 1'b0; reg_widx = '0; reg_wdata = '0;
    reg_ridx = '0; start = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!running && !done && cycle_count == 0, "R1", "in reset",
        {running, done, cycle_count}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!running && !done && cycle_count == 0, "R1", "after release",
        {running, done, cycle_count}, 0);

    // R3 lane isolation: all-ones plus one wraps per lane, no cross carry
    rand_regs();
    init_regs[2] = {4{32'hFFFF_FFFF}};
    init_regs[3] = {4{32'h0000_0001}};
    plen = 4;
    prog[0] = enc(0, 1, 2, 3);
    prog[1] = enc(1, 4, 3, 2);
    prog[2] = enc(2, 5, 6, 0);
    prog[3] = enc(3, 6, 2, 0);
    do_run("ops", 1'b0);
    chk(exp_regs[1] == 128'd0, "R2", "lane wrap expectation", exp_regs[1], 128'd0);

    // R5: dependent pair takes longer than independent pair
    rand_regs();
    plen = 2;
    prog[0] = enc(0, 1, 2, 3);
    prog[1] = enc(0, 4, 5, 6);
    do_run("indep", 1'b0);
    c_ind = int'(cycle_count);
    chk(cycle_count == 16'd3, "R6", "independent pair cycles", cycle_count, 3);
    prog[1] = enc(0, 4, 1, 5);
    do_run("dep", 1'b0);
    c_dep = int'(cycle_count);
    chk(cycle_count == 16'd4, "R5", "dependent pair cycles", cycle_count, 4);
    chk(c_dep > c_ind, "R5", "dependent slower", c_dep, c_ind + 1);

    // R9: done and count hold while idle
    held = cycle_count;
    repeat (5) @(negedge clk);
    chk(done && cycle_count == held, "R9", "hold after done", cycle_count, held);

    // R5: source B is waited on even for a copy
    plen = 2;
    prog[0] = enc(1, 3, 1, 2);
    prog[1] = enc(2, 4, 5, 3);
    do_run("movwait", 1'b0);
    chk(cycle_count == 16'd5, "R5", "copy waits on B", cycle_count, 5);

    // R7: long write replaced by a short one; reader sees the short value early
    rand_regs();
    plen = 3;
    prog[0] = enc(1, 1, 2, 3);
    prog[1] = enc(2, 1, 3, 3);
    prog[2] = enc(0, 4, 1, 1);
    do_run("overwrite_short", 1'b0);
    chk(cycle_count == 16'd4, "R7", "shortened wait cycles", cycle_count, 4);

    // R7: short write replaced by a long one in the cycle the first drains
    plen = 2;
    prog[0] = enc(0, 1, 2, 3);
    prog[1] = enc(1, 1, 5, 6);
    do_run("overwrite_long", 1'b0);
    chk(cycle_count == 16'd5, "R7", "lengthened wait cycles", cycle_count, 5);

    // R4: each latency measured alone
    for (int op = 0; op < 4; op++) begin
      plen = 1;
      prog[0] = enc(op, 2, 3, 4);
      do_run($sformatf("lat%0d", op), 1'b0);
      chk(cycle_count == 16'(lat_of(2'(op))), "R4", $sformatf("latency op %0d", op),
          cycle_count, lat_of(2'(op)));
    end

    // R8: empty program
    plen = 0;
    do_run("empty", 1'b0);
    chk(cycle_count == 16'd0, "R8", "empty program", cycle_count, 0);

    // R10: writes during a run are ignored (program never writes r7)
    rand_regs();
    plen = 4;
    prog[0] = enc(1, 1, 2, 3);
    prog[1] = enc(1, 2, 1, 3);
    prog[2] = enc(1, 3, 2, 1);
    prog[3] = enc(0, 4, 3, 7);
    do_run("poke", 1'b1);
    reg_ridx = 3'd7;
    #1;
    chk(reg_rdata == init_regs[7], "R10", "r7 untouched", reg_rdata, init_regs[7]);

    // Randomized programs, R6 ordering and R7 overwrites arise naturally
    for (int k = 0; k < 24; k++) begin
      rand_regs();
      plen = 1 + int'($urandom_range(15));
      for (int i = 0; i < plen; i++)
        prog[i] = 11'($urandom);
      do_run($sformatf("rand%0d", k), 1'b0);
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule